// File: doc/BRIEF.md
# Regulator Fault Counter Manager

This block supervises a set of power rails on behalf of a start-up sequencer. It takes fault pulses from external comparators: undervoltage per rail, overcurrent on the memory core rail, overvoltage on the memory core and memory termination rails, and an over-temperature flag. From these it produces a per-rail disable mask, a request that asks the sequencer to retry the disabled rails, and a latched shutdown flag.

Recoverable faults are undervoltage and overcurrent. Each one disables only the rails it concerns and adds one to a fault tally. A quiet-time counter clears the tally after a long enough stretch without faults. If faults pile up faster than that, the tally crosses a limit and the block latches a full shutdown. The limit is lower while the system is coming up from full shutdown (S5) than at other times.

Overvoltage and over-temperature bypass the tally. Each sets its own latch, and each latch has its own clear rule. The S5 sleep input and the supply power-on reset pulse are the only ways to clear these latches.

Top module: `rail_fault_mgr`

## Requirements
- R1: After reset, rail_dis_o is all zero, restart_req_o is 0 and shutdown_o is 0.
- R2: A rising undervoltage input on an enabled rail sets only that rail's bit of rail_dis_o on the next clock edge and raises restart_req_o. The other bits are unchanged. retry_i clears every disable bit.
- R3: A rising oc_core_i disables the core rail (bit CORE_IDX, default 0) and the termination rail (bit TERM_IDX, default 1) together. It adds exactly one to the tally.
- R4: Fault inputs are edge-sensitive. A fault level held high counts once. It counts again only after a retry_i pulse has re-enabled that rail.
- R5: When QUIET_LIMIT tick_i pulses pass with no counted fault, the tally clears. Every counted fault restarts this quiet window. With tick_i low the window does not advance.
- R6: shutdown_o latches when the tally reaches COLD_LIMIT (4) while cold_start_i is 1, or reaches WARM_LIMIT (5) while cold_start_i is 0. In shutdown, rail_dis_o is all ones, restart_req_o is 0 and new faults are ignored.
- R7: ov_core_i or ov_term_i latches shutdown_o on the next edge. Only s5_n_i going low and then high clears it. por_i has no effect on it.
- R8: therm_i latches shutdown_o. It clears only when therm_i is low and, in the same cycle, either por_i is high or s5_n_i rises after having been low.
- R9: Faults that arrive in the same cycle each add one to the tally.
- R10: s5_n_i low means the S5 state. While it is low, the tally, the quiet window and the disable mask are held at zero and fault inputs are ignored. Its rising edge clears a tally shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Quiet-window advance strobe |
| cold_start_i | input | 1 | 1 while starting from S5 |
| s5_n_i | input | 1 | S5 sleep input, low = S5 |
| por_i | input | 1 | Supply power-on reset recurrence pulse |
| retry_i | input | 1 | Sequencer starts a retry of disabled rails |
| uv_i | input | NUM_RAILS | Undervoltage flag per rail |
| oc_core_i | input | 1 | Overcurrent on memory core rail |
| ov_core_i | input | 1 | Overvoltage on memory core rail |
| ov_term_i | input | 1 | Overvoltage on memory termination rail |
| therm_i | input | 1 | Over-temperature flag |
| rail_dis_o | output | NUM_RAILS | Per-rail disable mask |
| restart_req_o | output | 1 | Retry request to the sequencer |
| shutdown_o | output | 1 | Latched global shutdown |

## Verification
A wrong tally or quiet-window value does not show at the ports at once. It shows up later, when a fault that should not have tripped shutdown_o trips it, or one that should have tripped it does not. For that reason the bench drives exact numbers of faults up to each limit, one below and at the limit, and then waits above and below the quiet window before counting again. A wrong latch or edge state shows on the next clock edge, as a missing or extra disable bit or a shutdown_o that fails to clear or fails to hold.

// File: rtl/rfm_pkg.sv
`timescale 1ns/1ps
package rfm_pkg;
  localparam int unsigned TALLY_W = 3;
  localparam logic [TALLY_W-1:0] TALLY_MAX = '1;
endpackage

// File: rtl/rfm_edge.sv
`timescale 1ns/1ps
module rfm_edge #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rearm_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g] & ~rearm_i[g];  // rearm lets a held level count again
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];

    p_once_per_attempt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_i[g] && !rearm_i[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/rfm_tally.sv
`timescale 1ns/1ps
module rfm_tally
  import rfm_pkg::*;
#(
  parameter int unsigned QUIET_LIMIT = 16384,
  parameter int unsigned COLD_LIMIT  = 4,
  parameter int unsigned WARM_LIMIT  = 5,
  parameter int unsigned EVT_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cold_i,
  input  logic             run_i,
  input  logic             clr_trip_i,
  input  logic [EVT_W-1:0] n_evt_i,
  output logic             trip_o
);
  localparam int unsigned QW = $clog2(QUIET_LIMIT + 1);
  localparam logic [QW-1:0] QLIM = QW'(QUIET_LIMIT);

  logic [TALLY_W-1:0] cnt_q, cnt_nxt;
  logic [QW-1:0]      quiet_q;
  int unsigned        sum, limit;

  always_comb begin
    sum     = int'(cnt_q) + int'(n_evt_i);
    cnt_nxt = (sum > int'(TALLY_MAX)) ? TALLY_MAX : TALLY_W'(sum);
    limit   = cold_i ? COLD_LIMIT : WARM_LIMIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      quiet_q <= '0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      quiet_q <= '0;
    end else if (n_evt_i != '0) begin
      cnt_q   <= cnt_nxt;
      quiet_q <= '0;
    end else if (tick_i && quiet_q != QLIM) begin
      quiet_q <= quiet_q + 1'b1;
      if (quiet_q == QLIM - 1'b1) cnt_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                 trip_o <= 1'b0;
    else if (clr_trip_i)                                         trip_o <= 1'b0;
    else if (run_i && n_evt_i != '0 && int'(cnt_nxt) >= limit)   trip_o <= 1'b1;
  end

  p_quiet_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && n_evt_i != '0 |=> quiet_q == '0);
  p_tally_trips_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && int'(cnt_q) >= WARM_LIMIT |-> trip_o);
endmodule

// File: rtl/rfm_latch.sv
`timescale 1ns/1ps
module rfm_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s5_n_i,
  input  logic por_i,
  input  logic ov_i,
  input  logic hot_i,
  output logic ov_o,
  output logic hot_o,
  output logic s5_rise_o
);
  logic s5_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s5_q <= 1'b1;
    else         s5_q <= s5_n_i;
  end
  assign s5_rise_o = s5_n_i & ~s5_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ov_o <= 1'b0;
    else if (ov_i)      ov_o <= 1'b1;
    else if (s5_rise_o) ov_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hot_o <= 1'b0;
    else if (hot_i)               hot_o <= 1'b1;
    else if (por_i || s5_rise_o)  hot_o <= 1'b0;
  end

  p_ov_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_i |=> ov_o);
  p_ov_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_o && !s5_rise_o |=> ov_o);
  p_hot_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_o && !por_i && !s5_rise_o |=> hot_o);
endmodule

// File: rtl/rail_fault_mgr.sv
`timescale 1ns/1ps
module rail_fault_mgr #(
  parameter int unsigned NUM_RAILS   = 5,
  parameter int unsigned CORE_IDX    = 0,
  parameter int unsigned TERM_IDX    = 1,
  parameter int unsigned QUIET_LIMIT = 16384,
  parameter int unsigned COLD_LIMIT  = 4,
  parameter int unsigned WARM_LIMIT  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 cold_start_i,
  input  logic                 s5_n_i,
  input  logic                 por_i,
  input  logic                 retry_i,
  input  logic [NUM_RAILS-1:0] uv_i,
  input  logic                 oc_core_i,
  input  logic                 ov_core_i,
  input  logic                 ov_term_i,
  input  logic                 therm_i,
  output logic [NUM_RAILS-1:0] rail_dis_o,
  output logic                 restart_req_o,
  output logic                 shutdown_o
);
  localparam int unsigned EW    = NUM_RAILS + 1;
  localparam int unsigned EVT_W = $clog2(NUM_RAILS + 2);

  logic [NUM_RAILS-1:0] dis_q, ev_uv, new_dis, oc_mask;
  logic [EW-1:0]        rise, rearm;
  logic [EVT_W-1:0]     n_evt;
  logic                 ev_oc, halt, trip, ov_lat, hot_lat, s5_rise;

  always_comb begin
    oc_mask           = '0;
    oc_mask[CORE_IDX] = 1'b1;
    oc_mask[TERM_IDX] = 1'b1;
  end

  assign rearm = retry_i ? {dis_q[CORE_IDX], dis_q} : '0;

  rfm_edge #(.W(EW)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   ({oc_core_i, uv_i}),
    .rearm_i (rearm),
    .rise_o  (rise)
  );

  assign shutdown_o = trip | ov_lat | hot_lat;
  assign halt       = shutdown_o | ~s5_n_i;
  assign ev_uv      = rise[NUM_RAILS-1:0] & ~dis_q & {NUM_RAILS{~halt}};
  assign ev_oc      = rise[NUM_RAILS] & ~dis_q[CORE_IDX] & ~halt;
  assign new_dis    = ev_uv | (ev_oc ? oc_mask : '0);

  always_comb begin
    n_evt = EVT_W'(ev_oc);
    for (int i = 0; i < NUM_RAILS; i++) n_evt = n_evt + EVT_W'(ev_uv[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dis_q <= '0;
    else if (!s5_n_i) dis_q <= '0;
    else if (retry_i) dis_q <= new_dis;
    else              dis_q <= dis_q | new_dis;
  end

  rfm_tally #(
    .QUIET_LIMIT (QUIET_LIMIT),
    .COLD_LIMIT  (COLD_LIMIT),
    .WARM_LIMIT  (WARM_LIMIT),
    .EVT_W       (EVT_W)
  ) u_tally (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cold_i     (cold_start_i),
    .run_i      (s5_n_i),
    .clr_trip_i (s5_rise),
    .n_evt_i    (n_evt),
    .trip_o     (trip)
  );

  rfm_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s5_n_i    (s5_n_i),
    .por_i     (por_i),
    .ov_i      (ov_core_i | ov_term_i),
    .hot_i     (therm_i),
    .ov_o      (ov_lat),
    .hot_o     (hot_lat),
    .s5_rise_o (s5_rise)
  );

  assign rail_dis_o    = dis_q | {NUM_RAILS{shutdown_o}};
  assign restart_req_o = (|dis_q) & ~shutdown_o;

  p_fault_disables_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s5_n_i && ev_uv != '0 |=> (rail_dis_o & $past(ev_uv)) == $past(ev_uv));
  p_halt_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s5_n_i |=> dis_q == '0);
endmodule

// File: tb/tb_rail_fault_mgr.sv
`timescale 1ns/1ps
module tb_rail_fault_mgr;
  localparam int N = 4;
  localparam int QL = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, cold = 1'b0, s5_n = 1'b1, por = 1'b0, retry = 1'b0;
  logic [N-1:0] uv = '0;
  logic oc = 1'b0, ovc = 1'b0, ovt = 1'b0, therm = 1'b0;
  logic [N-1:0] dis;
  logic req, sd;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  rail_fault_mgr #(.NUM_RAILS(N), .CORE_IDX(0), .TERM_IDX(1), .QUIET_LIMIT(QL),
                   .COLD_LIMIT(4), .WARM_LIMIT(5)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cold_start_i(cold), .s5_n_i(s5_n),
    .por_i(por), .retry_i(retry), .uv_i(uv), .oc_core_i(oc), .ov_core_i(ovc),
    .ov_term_i(ovt), .therm_i(therm), .rail_dis_o(dis), .restart_req_o(req),
    .shutdown_o(sd));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_retry();
    retry = 1'b1; step(1); retry = 1'b0;
  endtask

  task automatic pulse_uv(input int i);
    uv[i] = 1'b1; step(1); uv[i] = 1'b0;
  endtask

  task automatic fault(input int i);
    pulse_uv(i); do_retry();
  endtask

  task automatic s5_cycle();
    s5_n = 1'b0; step(2); s5_n = 1'b1; step(1);
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3); rst_n = 1'b1; step(1);
    // R1
    chk("R1 dis", dis, 0); chk("R1 req", req, 0); chk("R1 sd", sd, 0);

    // R2
    pulse_uv(2);
    chk("R2 dis", dis, 4'b0100); chk("R2 req", req, 1);
    do_retry();
    chk("R2 retry dis", dis, 0); chk("R2 retry req", req, 0);

    // R3
    oc = 1'b1; step(1); oc = 1'b0;
    chk("R3 dis", dis, 4'b0011);
    do_retry();
    s5_cycle();
    chk("R10 dis after S5", dis, 0);

    // R4: held level counts once, recounts after retry (tally 2), then 2 more = 4 of 5
    uv[3] = 1'b1; step(5);
    chk("R4 held dis", dis, 4'b1000);
    do_retry();
    chk("R4 retry dis", dis, 0);
    step(1);
    chk("R4 recount dis", dis, 4'b1000);
    uv[3] = 1'b0; do_retry();
    fault(0); fault(2);
    chk("R4 tally four no sd", sd, 0);
    fault(1);
    chk("R6 warm fifth sd", sd, 1);
    chk("R6 all disabled", dis, 4'b1111);
    chk("R6 no req", req, 0);
    s5_cycle();
    chk("R10 s5 clears trip", sd, 0);

    // R6 cold limit
    cold = 1'b1;
    fault(0); fault(1); fault(2);
    chk("R6 cold three no sd", sd, 0);
    fault(3);
    chk("R6 cold fourth sd", sd, 1);
    cold = 1'b0; s5_cycle();

    // R9 simultaneous faults count 3
    uv[0] = 1'b1; uv[1] = 1'b1; oc = 1'b1; step(1);
    uv = '0; oc = 1'b0;
    chk("R9 dis", dis, 4'b0011);
    do_retry();
    fault(2);
    chk("R9 four no sd", sd, 0);
    fault(3);
    chk("R9 fifth sd", sd, 1);
    s5_cycle();

    // R5 quiet window clears tally
    for (int k = 0; k < 4; k++) fault(k);
    step(QL + 8);
    for (int k = 0; k < 4; k++) fault(k);
    chk("R5 cleared no sd", sd, 0);
    fault(0);
    chk("R5 after clear fifth sd", sd, 1);
    s5_cycle();
    // R5 tick low does not advance
    for (int k = 0; k < 4; k++) fault(k);
    tick = 1'b0; step(QL + 8); tick = 1'b1;
    fault(0);
    chk("R5 no tick sd", sd, 1);
    s5_cycle();
    // R5 each fault restarts window
    for (int k = 0; k < 3; k++) fault(k);
    step(QL - 12); fault(3);
    step(QL - 12); fault(0);
    chk("R5 restart window sd", sd, 1);
    s5_cycle();

    // R7 overvoltage
    ovt = 1'b1; step(1); ovt = 1'b0;
    chk("R7 ov sd", sd, 1); chk("R7 ov dis", dis, 4'b1111);
    por = 1'b1; step(1); por = 1'b0;
    chk("R7 por no clear", sd, 1);
    s5_cycle();
    chk("R7 s5 clears", sd, 0);
    ovc = 1'b1; step(1); ovc = 1'b0;
    chk("R7 core ov sd", sd, 1);
    s5_cycle();

    // R8 thermal
    therm = 1'b1; step(1);
    chk("R8 hot sd", sd, 1);
    s5_cycle();
    chk("R8 s5 while hot holds", sd, 1);
    therm = 1'b0; step(2);
    chk("R8 cool alone holds", sd, 1);
    por = 1'b1; step(1); por = 1'b0;
    chk("R8 por clears", sd, 0);
    therm = 1'b1; step(1); therm = 1'b0; step(1);
    s5_cycle();
    chk("R8 s5 clears when cool", sd, 0);

    // R10 faults ignored while in S5
    s5_n = 1'b0; step(1);
    pulse_uv(1);
    chk("R10 ignored in S5", dis, 0);
    s5_n = 1'b1; step(1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule